// File: doc/BRIEF.md
# Multi-channel compare timer/counter

This block is a memory-mapped timer with four compare channels and one level interrupt. In timer mode a 32-bit counter advances on a tick derived from the block clock. The clock is treated as the 16 MHz base, and the tick rate is that base divided by a power of two chosen by a prescaler. In counter mode the counter advances once for each count task written by software. Every tick is compared against all channel compare values. A match raises a sticky event flag, and per-channel shortcut bits can clear or stop the counter on that match.

Software works through a simple 32-bit word port: a write strobe, a word address and write data, plus a combinational read-data path. Tasks are triggered by writing the value 1 to a task address. The interrupt is the OR of the event flags gated by per-channel enables, which are kept in bits 16 and up of a set/clear register pair. The counter can only be observed by capturing it into a compare register.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter, running state, event flags, compare registers, shortcuts, interrupt enables, mode, width and prescaler are all zero, and `irq_o` is low.
- R2: The width field (address 29) selects the counter size: 0 = 16, 1 = 8, 2 = 24 and 3 = 32 bits. The counter wraps to 0 modulo 2^width, and a write to a compare register is stored modulo 2^width.
- R3: In timer mode (mode 0, address 28) the running counter advances once every 2^p clock cycles, where p is the prescaler (address 30). A prescaler write above 9 stores 9. Writing the prescaler restarts the divider, so the first tick comes 2^p cycles after the write.
- R4: The start task (address 0) sets the timer running only in timer mode. The stop (address 1) and shutdown (address 4) tasks both halt counting.
- R5: The count task (address 2) adds one to the counter only in counter mode (mode 1). It has no effect in timer mode.
- R6: When the counter steps onto the value of compare register i (address 32+i), event flag i (address 16+i, bit 0) is set. The flag stays set until 0 is written to it, and a nonzero write leaves it set.
- R7: With shortcut bit i (0..3, address 24) set, a match on channel i loads the counter with 0 in place of the matched value. Channels that match together all set their flags in the same cycle.
- R8: With shortcut bit 8+i set, a match on channel i stops the timer.
- R9: `irq_o` is the OR over i of flag i AND enable bit 16+i. A write to the enable-set register (address 25) ORs in the written bits 16..19. A write to the enable-clear register (address 26) clears the bits written as 1. Both addresses read back the enable mask in bits 16..19.
- R10: The clear task (address 3) zeroes the counter in either mode, and takes priority over a tick in the same cycle. The capture task i (address 8+i) copies the counter into compare register i.
- R11: A task acts only when the written value is exactly 1. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, used as the 16 MHz base tick |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen_i | input | 1 | Write strobe for one word |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check, on every cycle, the counter step rule: an increment modulo the selected width, with the clear task and the clear shortcut both forcing zero. They also check that a stop shortcut drops the running state, that a start is ignored in counter mode, that a match always sets its flag and the flag holds until cleared, and that the divider never emits back-to-back ticks when the prescaler is nonzero. The bench scenarios are needed for the exact tick counts over a timed window, the reduction of compare writes under each width, wrap-around at 8 bits, the enable set/clear readback and its effect on the interrupt, and a long random mix of count, clear, capture and compare writes checked against a bench model.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 32;

  typedef enum logic {MODE_TIMER = 1'b0, MODE_COUNT = 1'b1} mode_e;

  localparam logic [ADDR_W-1:0] A_START  = 6'd0;
  localparam logic [ADDR_W-1:0] A_STOP   = 6'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 6'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 6'd3;
  localparam logic [ADDR_W-1:0] A_SHUT   = 6'd4;
  localparam logic [ADDR_W-1:0] A_CAP    = 6'd8;
  localparam logic [ADDR_W-1:0] A_EVT    = 6'd16;
  localparam logic [ADDR_W-1:0] A_SHORTS = 6'd24;
  localparam logic [ADDR_W-1:0] A_IE_SET = 6'd25;
  localparam logic [ADDR_W-1:0] A_IE_CLR = 6'd26;
  localparam logic [ADDR_W-1:0] A_MODE   = 6'd28;
  localparam logic [ADDR_W-1:0] A_WIDTH  = 6'd29;
  localparam logic [ADDR_W-1:0] A_PSC    = 6'd30;
  localparam logic [ADDR_W-1:0] A_CC     = 6'd32;

  function automatic logic [CNT_W-1:0] width_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_FFFF;
      2'd1:    return 32'h0000_00FF;
      2'd2:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cmp_timer_div.sv
module cmp_timer_div #(
  parameter int PSC_MAX = 9,
  parameter int PSC_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int DIV_W = (PSC_MAX > 0) ? PSC_MAX : 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  assign lim    = DIV_W'((33'd1 << psc_i) - 33'd1);
  assign tick_o = (div_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else if (tick_o)    div_q <= '0;
    else                div_q <= div_q + DIV_W'(1);
  end

  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && psc_i != '0 && !restart_i) |=> !tick_o);
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
  import cmp_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cc_we_i,
  input  logic             cap_i,
  input  logic             evt_clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] nxt_i,
  output logic [CNT_W-1:0] cc_o,
  output logic             evt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cc_q;
  logic             evt_q;

  assign match_o = tick_i && (nxt_i == cc_q);
  assign cc_o    = cc_q;
  assign evt_o   = evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cc_q <= '0;
    else if (cap_i)   cc_q <= cnt_i;
    else if (cc_we_i) cc_q <= wdata_i & mask_i;
  end

  // a match in the same cycle as a clear write wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        evt_q <= 1'b0;
    else if (match_o)   evt_q <= 1'b1;
    else if (evt_clr_i) evt_q <= 1'b0;
  end

  p_evt_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> evt_q);
  p_evt_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && !evt_clr_i) |=> evt_q);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int PSC_MAX = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wen_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int PSC_W = $clog2(PSC_MAX + 1);

  mode_e            mode_q;
  logic [1:0]       width_q;
  logic [PSC_W-1:0] psc_q;
  logic [NCH-1:0]   sc_clr_q, sc_stop_q, inten_q;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q, nxt, mask;

  logic [NCH-1:0]   match, evt, cc_we, cap, evt_clr;
  logic [CNT_W-1:0] cc [NCH];
  logic             trig, t_start, t_stop, t_count, t_clear, psc_we, psc_tick;
  logic             tick, hit_clr, hit_stop;

  assign trig    = wen_i && (wdata_i == 32'd1);
  assign t_start = trig && addr_i == A_START;
  assign t_stop  = trig && (addr_i == A_STOP || addr_i == A_SHUT);
  assign t_count = trig && addr_i == A_COUNT;
  assign t_clear = trig && addr_i == A_CLEAR;
  assign psc_we  = wen_i && addr_i == A_PSC;

  assign mask = width_mask(width_q);
  assign nxt  = (cnt_q + 32'd1) & mask;
  assign tick = (mode_q == MODE_TIMER && run_q && psc_tick) ||
                (mode_q == MODE_COUNT && t_count);
  assign hit_clr  = |(match & sc_clr_q);
  assign hit_stop = |(match & sc_stop_q);
  assign irq_o    = |(evt & inten_q);

  cmp_timer_div #(.PSC_MAX(PSC_MAX), .PSC_W(PSC_W)) u_div (
    .clk_i, .rst_ni, .psc_i(psc_q), .restart_i(psc_we), .tick_o(psc_tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cc_we[i]   = wen_i && addr_i == A_CC + ADDR_W'(i);
    assign cap[i]     = trig && addr_i == A_CAP + ADDR_W'(i);
    assign evt_clr[i] = wen_i && addr_i == A_EVT + ADDR_W'(i) && wdata_i == 32'd0;

    cmp_timer_chan u_ch (
      .clk_i, .rst_ni,
      .cc_we_i(cc_we[i]), .cap_i(cap[i]), .evt_clr_i(evt_clr[i]), .tick_i(tick),
      .wdata_i, .mask_i(mask), .cnt_i(cnt_q), .nxt_i(nxt),
      .cc_o(cc[i]), .evt_o(evt[i]), .match_o(match[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (t_clear) cnt_q <= '0;
    else if (tick)    cnt_q <= hit_clr ? '0 : nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              run_q <= 1'b0;
    else if (t_stop || hit_stop)              run_q <= 1'b0;
    else if (t_start && mode_q == MODE_TIMER) run_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_TIMER;
      width_q   <= '0;
      psc_q     <= '0;
      sc_clr_q  <= '0;
      sc_stop_q <= '0;
      inten_q   <= '0;
    end else if (wen_i) begin
      case (addr_i)
        A_MODE:   mode_q  <= mode_e'(wdata_i[0]);
        A_WIDTH:  width_q <= wdata_i[1:0];
        A_PSC:    psc_q   <= (wdata_i > 32'(PSC_MAX)) ? PSC_W'(PSC_MAX) : wdata_i[PSC_W-1:0];
        A_SHORTS: begin
          sc_clr_q  <= wdata_i[NCH-1:0];
          sc_stop_q <= wdata_i[8 +: NCH];
        end
        A_IE_SET: inten_q <= inten_q | wdata_i[16 +: NCH];
        A_IE_CLR: inten_q <= inten_q & ~wdata_i[16 +: NCH];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_SHORTS: begin
        rdata_o[NCH-1:0]  = sc_clr_q;
        rdata_o[8 +: NCH] = sc_stop_q;
      end
      A_IE_SET, A_IE_CLR: rdata_o[16 +: NCH] = inten_q;
      A_MODE:  rdata_o[0]         = mode_q;
      A_WIDTH: rdata_o[1:0]       = width_q;
      A_PSC:   rdata_o[PSC_W-1:0] = psc_q;
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == A_EVT + ADDR_W'(i)) rdata_o = {31'b0, evt[i]};
      if (addr_i == A_CC + ADDR_W'(i))  rdata_o = cc[i];
    end
  end

  p_clear_task_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_clear |=> cnt_q == '0);
  p_short_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && hit_clr) |=> cnt_q == '0);
  p_short_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_stop |=> !run_q);
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !hit_clr && !t_clear) |=> cnt_q == (($past(cnt_q) + 32'd1) & $past(mask)));
  p_start_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_start && mode_q == MODE_COUNT && !run_q) |=> !run_q);
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  localparam logic [5:0] START = 0, STOP = 1, COUNT = 2, CLEAR = 3, SHUT = 4;
  localparam logic [5:0] CAP = 8, EVT = 16, SHORTS = 24, IESET = 25, IECLR = 26;
  localparam logic [5:0] MODE = 28, WIDTH = 29, PSC = 30, CC = 32;

  logic clk = 0, rst_ni = 0, wen = 0;
  logic [5:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int total = 0, bad = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  cmp_timer u0 (.clk_i(clk), .rst_ni(rst_ni), .wen_i(wen), .addr_i(addr),
                .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  function automatic logic [31:0] wmask(input int code);
    case (code)
      0: return 32'hFFFF;
      1: return 32'hFF;
      2: return 32'hFF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wen = 1; addr = a; wdata = d;
    @(negedge clk);
    wen = 0; wdata = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic cap_rd(input int ch, output logic [31:0] d);
    wr(CAP + 6'(ch), 1);
    rd(CC + 6'(ch), d);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] cnt_m, m;
    logic [31:0] cc_m [4];
    logic [3:0]  evt_m;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    foreach (cc_m[i]) begin rd(CC + 6'(i), v); chk("R1 cc", v, 0); end
    rd(EVT, v); chk("R1 evt", v, 0);
    rd(SHORTS, v); chk("R1 shorts", v, 0);
    rd(IESET, v); chk("R1 inten", v, 0);
    rd(MODE, v); chk("R1 mode", v, 0);
    rd(WIDTH, v); chk("R1 width", v, 0);
    rd(PSC, v); chk("R1 psc", v, 0);
    cap_rd(3, v); chk("R1 counter", v, 0);

    // R3 timer rate with prescaler 2, then 0
    wr(CLEAR, 1); wr(PSC, 2); wr(START, 1);
    repeat (40) @(negedge clk);
    wr(STOP, 1);
    cap_rd(0, v); chk("R3 psc2 ticks", v, 10);
    wr(CLEAR, 1); wr(PSC, 0); wr(START, 1);
    repeat (40) @(negedge clk);
    wr(STOP, 1);
    cap_rd(0, v); chk("R3 psc0 ticks", v, 41);
    wr(PSC, 15); rd(PSC, v); chk("R3 psc clamp", v, 9);
    wr(PSC, 0);

    // R5 count ignored in timer mode
    wr(CLEAR, 1); wr(COUNT, 1); wr(COUNT, 1);
    cap_rd(0, v); chk("R5 count in timer mode", v, 0);

    // R4 start ignored in counter mode; shutdown halts
    wr(MODE, 1); wr(START, 1); wr(MODE, 0);
    repeat (10) @(negedge clk);
    cap_rd(0, v); chk("R4 start in counter mode", v, 0);
    wr(CLEAR, 1); wr(START, 1);
    repeat (5) @(negedge clk);
    wr(SHUT, 1);
    cap_rd(0, v); chk("R4 shutdown value", v, 6);
    repeat (10) @(negedge clk);
    cap_rd(1, v); chk("R4 shutdown holds", v, 6);

    // R8 stop shortcut on channel 1
    wr(CC + 1, 5); wr(SHORTS, 32'h200); wr(CLEAR, 1); wr(START, 1);
    repeat (20) @(negedge clk);
    cap_rd(0, v); chk("R8 stopped at compare", v, 5);
    rd(EVT + 1, v); chk("R8 evt1", v, 1);
    wr(STOP, 1);

    // R11 nonzero event write kept, non-1 task write ignored, unmapped read
    wr(EVT + 1, 5); rd(EVT + 1, v); chk("R11 evt nonzero write", v, 1);
    wr(EVT + 1, 0); rd(EVT + 1, v); chk("R6 evt clear", v, 0);
    wr(MODE, 1); wr(CLEAR, 1); wr(COUNT, 2); wr(COUNT, 32'h101);
    cap_rd(0, v); chk("R11 count value 2 ignored", v, 0);
    rd(6'd7, v); chk("R11 unmapped read", v, 0);
    rd(6'd63, v); chk("R11 unmapped read hi", v, 0);

    // R7 clear shortcut and simultaneous matches (counter mode)
    for (int i = 0; i < 4; i++) wr(EVT + 6'(i), 0);
    wr(CC + 0, 3); wr(CC + 1, 2); wr(CC + 2, 2); wr(CC + 3, 32'hFFFF);
    wr(SHORTS, 1); wr(CLEAR, 1);
    wr(COUNT, 1); wr(COUNT, 1);
    rd(EVT + 1, v); chk("R7 evt1 together", v, 1);
    rd(EVT + 2, v); chk("R7 evt2 together", v, 1);
    rd(EVT + 0, v); chk("R6 evt0 not yet", v, 0);
    wr(COUNT, 1);
    rd(EVT + 0, v); chk("R7 evt0", v, 1);
    cap_rd(3, v); chk("R7 cleared on match", v, 0);
    wr(COUNT, 1); wr(COUNT, 1);
    cap_rd(3, v); chk("R7 counts after clear", v, 2);
    wr(SHORTS, 0);

    // R9 interrupt enables (evt0..2 set, evt3 clear)
    wr(EVT + 3, 0);
    chk("R9 irq none enabled", {31'b0, irq}, 0);
    wr(IESET, 32'hFFFF_FFFF); rd(IESET, v); chk("R9 set readback", v, 32'h000F_0000);
    wr(IECLR, 32'h0007_0000); rd(IECLR, v); chk("R9 clr readback", v, 32'h0008_0000);
    chk("R9 irq only ch3 enabled", {31'b0, irq}, 0);
    wr(IESET, 32'h0002_0000); chk("R9 irq ch1", {31'b0, irq}, 1);
    wr(EVT + 1, 0); chk("R9 irq after evt1 clear", {31'b0, irq}, 0);

    // R2 width reduction and 8-bit wrap
    wr(WIDTH, 0); wr(CC + 0, 32'h0001_2345); rd(CC + 0, v); chk("R2 16-bit cc", v, 32'h2345);
    wr(WIDTH, 2); wr(CC + 0, 32'hAB12_3456); rd(CC + 0, v); chk("R2 24-bit cc", v, 32'h12_3456);
    wr(WIDTH, 1); wr(CC + 0, 32'h0000_0134); rd(CC + 0, v); chk("R2 8-bit cc", v, 32'h34);
    wr(CC + 0, 32'h100); wr(EVT + 0, 0); wr(CLEAR, 1);
    repeat (256) wr(COUNT, 1);
    cap_rd(1, v); chk("R2 8-bit wrap", v, 0);
    rd(EVT + 0, v); chk("R6 match on wrap", v, 1);
    wr(COUNT, 1); wr(CLEAR, 1); cap_rd(1, v); chk("R10 clear task", v, 0);

    // random mix in counter mode, 8-bit width, against a bench model
    m = wmask(1);
    cnt_m = 0; evt_m = 0;
    for (int i = 0; i < 4; i++) begin wr(CC + 6'(i), 0); wr(EVT + 6'(i), 0); cc_m[i] = 0; end
    wr(CLEAR, 1);
    for (int n = 0; n < 500; n++) begin
      int unsigned r = $urandom_range(99);
      int ch = $urandom_range(3);
      logic [31:0] d, nx;
      if (r < 55) begin
        wr(COUNT, 1);
        nx = (cnt_m + 1) & m;
        for (int i = 0; i < 4; i++) if (nx == cc_m[i]) evt_m[i] = 1'b1;
        cnt_m = nx;
      end else if (r < 62) begin
        wr(CLEAR, 1); cnt_m = 0;
      end else if (r < 75) begin
        cap_rd(ch, v); cc_m[ch] = cnt_m; chk("R10 random capture", v, cnt_m);
      end else if (r < 88) begin
        d = $urandom;
        wr(CC + 6'(ch), d); cc_m[ch] = d & m;
        rd(CC + 6'(ch), v); chk("R2 random cc write", v, cc_m[ch]);
      end else if (r < 94) begin
        rd(EVT + 6'(ch), v); chk("R6 random evt", v, {31'b0, evt_m[ch]});
      end else begin
        wr(EVT + 6'(ch), 0); evt_m[ch] = 1'b0;
      end
    end
    for (int i = 0; i < 4; i++) begin
      rd(EVT + 6'(i), v); chk("R6 final evt", v, {31'b0, evt_m[i]});
    end
    finish_run();
  end
endmodule